// File: doc/BRIEF.md
# Next Program Counter Unit

This block sits in the fetch stage of a simple 32-bit RISC core. It holds the program counter and works out, from the instruction word being fetched and a flag saying whether the two source registers compared equal, the address of the next instruction to fetch. The flag is produced elsewhere and is an input here. The block reads the 6-bit opcode in bits [31:26] and recognises three control-transfer kinds: an unconditional jump, a branch taken on equality, and a branch taken on inequality. Every other opcode moves on to the next sequential word.

Instructions are 4-byte words. Both branch offsets and jump fields count words, not bytes. A branch adds a signed word offset to the address of the following instruction. A jump keeps the four upper bits of the incremented PC and replaces the lower 28 bits with the jump field scaled to bytes. The PC register loads the chosen address on every clock where the enable input is high. A synchronous active-high reset loads a parameterised start address. The next address and a taken flag are also visible combinationally, so the surrounding pipeline can act on them in the current cycle.

Top module: `npc_unit`

## Requirements
- R1: With `rst` high at a rising clock edge, `pc_o` becomes `RESET_ADDR` after that edge, whatever `en` is.
- R2: With `rst` low and `en` low at a rising edge, `pc_o` keeps its value.
- R3: With `rst` low and `en` high at a rising edge, `pc_o` takes the value that `next_pc_o` showed before the edge.
- R4: For any opcode (bits [31:26]) other than 2, 4 and 5, `next_pc_o` is `pc_o + 4` modulo 2^32 and `taken_o` is 0.
- R5: For opcode 4 (branch on equal) with `regs_eq_i` = 1, `next_pc_o` is `pc_o + 4 + 4*offset`, where offset is bits [15:0] read as a signed value. `taken_o` is 1, so an offset of 1 skips exactly one instruction.
- R6: For opcode 4 with `regs_eq_i` = 0, `next_pc_o` is `pc_o + 4` and `taken_o` is 0.
- R7: For opcode 5 (branch on not equal), the branch is taken exactly when `regs_eq_i` = 0, with the same target rule as R5. When it is not taken, `next_pc_o` is `pc_o + 4` and `taken_o` is 0.
- R8: A branch offset with bit 15 set is sign-extended, so the taken target lies below `pc_o + 4` (for example, an offset of 0xFFFC moves back 16 bytes from `pc_o + 4`).
- R9: For opcode 2 (jump), `taken_o` is 1 regardless of `regs_eq_i`. `next_pc_o[27:0]` is bits [25:0] of the instruction followed by two zero bits.
- R10: For a jump, `next_pc_o[31:28]` equals bits [31:28] of `pc_o + 4`, not of `pc_o`. This matters when the jump sits in the last word of a 256 MB region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, loads `RESET_ADDR` |
| en | input | 1 | PC update enable |
| instr_i | input | 32 | Instruction word at the current PC |
| regs_eq_i | input | 1 | 1 when the two source registers compared equal |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address selected for the next fetch |
| taken_o | output | 1 | 1 when a jump or a taken branch redirects fetch |

## Verification
The bench builds the unit with `RESET_ADDR` set to 0x0FFF_FFF8, two words below a 256 MB region boundary. The first sequential step lands on the last word of region 0. A jump placed there must take its upper four bits from the incremented PC, which is already in region 1. This exposes any design that takes the region bits from the unincremented PC. From that point, directed branch cases in both polarities and both offset signs run first. A long stream of mixed instructions with random enables then follows, and each cycle is compared against a behavioural model of the PC.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN       = 32;
    localparam int OPC_W      = 6;
    localparam int OFF_W      = 16;
    localparam int JIDX_W     = 26;
    localparam int WORD_SHIFT = 2;
    localparam int REGION_W   = XLEN - JIDX_W - WORD_SHIFT;
    localparam int STEP_BYTES = 1 << WORD_SHIFT;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_JUMP = 2'd1,
        FLOW_BEQ  = 2'd2,
        FLOW_BNE  = 2'd3
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [OFF_W-1:0]   offset;
        logic [JIDX_W-1:0]  jidx;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] jmp;
    } targets_t;

    function automatic flow_e classify(input logic [OPC_W-1:0] opc);
        flow_e k;
        unique case (opc)
            OPC_JUMP: k = FLOW_JUMP;
            OPC_BEQ:  k = FLOW_BEQ;
            OPC_BNE:  k = FLOW_BNE;
            default:  k = FLOW_SEQ;
        endcase
        return k;
    endfunction

    function automatic logic [XLEN-1:0] scale_offset(input logic [OFF_W-1:0] off);
        logic [XLEN-WORD_SHIFT-1:0] ext;
        ext = {{(XLEN-WORD_SHIFT-OFF_W){off[OFF_W-1]}}, off};
        return {ext, {WORD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output dec_t            dec_o
);
    always_comb begin
        dec_o.kind   = classify(instr_i[XLEN-1 -: OPC_W]);
        dec_o.offset = instr_i[OFF_W-1:0];
        dec_o.jidx   = instr_i[JIDX_W-1:0];
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]   pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output targets_t          tgt_o
);
    logic [XLEN-1:0] inc;

    always_comb begin
        inc       = pc_i + XLEN'(STEP_BYTES);
        tgt_o.seq = inc;
        tgt_o.br  = inc + scale_offset(offset_i);
        tgt_o.jmp = {inc[XLEN-1 -: REGION_W], jidx_i, {WORD_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_e           kind_i,
    input  logic            regs_eq_i,
    input  targets_t        tgt_i,
    output logic [XLEN-1:0] next_o,
    output logic            taken_o
);
    always_comb begin
        unique case (kind_i)
            FLOW_JUMP: taken_o = 1'b1;
            FLOW_BEQ:  taken_o = regs_eq_i;
            FLOW_BNE:  taken_o = ~regs_eq_i;
            default:   taken_o = 1'b0;
        endcase

        if (!taken_o)
            next_o = tgt_i.seq;
        else if (kind_i == FLOW_JUMP)
            next_o = tgt_i.jmp;
        else
            next_o = tgt_i.br;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] instr_i,
    input  logic        regs_eq_i,
    output logic [31:0] pc_o,
    output logic [31:0] next_pc_o,
    output logic        taken_o
);
    logic [XLEN-1:0] pc_q;
    dec_t            dec;
    targets_t        tgt;

    npc_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    npc_targets u_targets (
        .pc_i     (pc_q),
        .offset_i (dec.offset),
        .jidx_i   (dec.jidx),
        .tgt_o    (tgt)
    );

    npc_select u_select (
        .kind_i    (dec.kind),
        .regs_eq_i (regs_eq_i),
        .tgt_i     (tgt),
        .next_o    (next_pc_o),
        .taken_o   (taken_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_ADDR;
        else if (en)
            pc_q <= next_pc_o;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [31:0] instr_i,
    input logic        regs_eq_i,
    input logic [31:0] pc_o,
    input logic [31:0] next_pc_o,
    input logic        taken_o
);
    logic [31:0] inc;
    logic [31:0] br_tgt;
    logic [5:0]  opc;
    assign inc    = pc_o + 32'd4;
    assign br_tgt = inc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
    assign opc    = instr_i[31:26];

    // R1
    reset_load_chk: assert property (@(posedge clk) rst |=> pc_o == RESET_ADDR);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(pc_o));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst) en |=> pc_o == $past(next_pc_o));

    // R4
    seq_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'd2 && opc != 6'd4 && opc != 6'd5) |-> (!taken_o && next_pc_o == inc));

    // R5
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && regs_eq_i) |-> (taken_o && next_pc_o == br_tgt));

    // R6
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && !regs_eq_i) |-> (!taken_o && next_pc_o == inc));

    // R7
    bne_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd5) |-> (taken_o == !regs_eq_i && next_pc_o == (regs_eq_i ? inc : br_tgt)));

    // R9
    jump_low_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd2) |-> (taken_o && next_pc_o[27:0] == {instr_i[25:0], 2'b00}));

    // R10
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd2) |-> next_pc_o[31:28] == inc[31:28]);
endmodule

bind npc_unit npc_unit_chk #(.RESET_ADDR(RESET_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .instr_i   (instr_i),
    .regs_eq_i (regs_eq_i),
    .pc_o      (pc_o),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] START = 32'h0FFF_FFF8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        regs_eq = 1'b0;
    logic [31:0] pc_o, next_pc_o;
    logic        taken_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;
    logic [31:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit #(.RESET_ADDR(START)) u_npc_unit (
        .clk(clk), .rst(rst), .en(en), .instr_i(instr), .regs_eq_i(regs_eq),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o)
    );

    task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int opc, input int fld);
        return {opc[5:0], fld[25:0]};
    endfunction

    task automatic step(input logic [31:0] ins, input logic eq, input logic e, input logic r, input string tag);
        int opc;
        longint off;
        logic [31:0] seq, exp_next;
        logic exp_taken;
        @(negedge clk);
        instr = ins; regs_eq = eq; en = e; rst = r;
        #1;
        opc = int'(ins[31:26]);
        seq = m_pc + 32'd4;
        off = longint'($signed(ins[15:0])) * 4;
        exp_taken = (opc == 2) || (opc == 4 && eq) || (opc == 5 && !eq);
        if (!exp_taken)
            exp_next = seq;
        else if (opc == 2)
            exp_next = (seq & 32'hF000_0000) | (ins[25:0] * 32'd4);
        else
            exp_next = 32'(longint'(seq) + off);
        check32(tag, "next_pc", next_pc_o, exp_next);
        check32(tag, "taken", {31'd0, taken_o}, {31'd0, exp_taken});
        @(posedge clk);
        if (r) m_pc = START;
        else if (e) m_pc = exp_next;
        #1;
        check32(r ? "R1" : (e ? "R3" : "R2"), "pc", pc_o, m_pc);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_pc = START;
        repeat (2) @(posedge clk);
        #1;
        check32("R1", "pc after reset", pc_o, START);
        // R4: register-type opcode 0 steps forward onto the last word of region 0
        step(32'h012A_4020, 1'b0, 1'b1, 1'b0, "R4");
        check32("R4", "pc at region end", pc_o, 32'h0FFF_FFFC);
        // R2: enable low, pc must not move even with a jump presented
        step(mk(2, 'h100), 1'b0, 1'b0, 1'b0, "R2");
        check32("R2", "pc held", pc_o, 32'h0FFF_FFFC);
        // R9 R10: jump region bits from pc+4 (0x1000_0000)
        step(mk(2, 'h100), 1'b0, 1'b1, 1'b0, "R10");
        check32("R10", "jump crosses region", pc_o, 32'h1000_0400);
        // R5: branch on equal, offset 1 skips one instruction
        step(mk(4, 32'h0274_0001), 1'b1, 1'b1, 1'b0, "R5");
        check32("R5", "skip one", pc_o, 32'h1000_0408);
        // R6: branch on equal not taken
        step(mk(4, 32'h0274_0009), 1'b0, 1'b1, 1'b0, "R6");
        check32("R6", "fall through", pc_o, 32'h1000_040C);
        // R7: branch on not equal, taken on inequality
        step(mk(5, 32'h0003), 1'b0, 1'b1, 1'b0, "R7");
        check32("R7", "bne taken", pc_o, 32'h1000_041C);
        step(mk(5, 32'h0003), 1'b1, 1'b1, 1'b0, "R7");
        check32("R7", "bne not taken", pc_o, 32'h1000_0420);
        // R8: negative offset 0xFFFC goes back 16 bytes from pc+4
        step(mk(4, 32'hFFFC), 1'b1, 1'b1, 1'b0, "R8");
        check32("R8", "backward", pc_o, 32'h1000_0414);
        // R4: opcodes 3 and 6 are sequential
        step(mk(3, 32'h3FF_FFFF), 1'b1, 1'b1, 1'b0, "R4");
        step(mk(6, 32'hFFFF), 1'b1, 1'b1, 1'b0, "R4");
        check32("R4", "seq opcodes", pc_o, 32'h1000_041C);
        // R9: jump ignores equality flag, full field
        step(mk(2, 32'h3FF_FFFF), 1'b1, 1'b1, 1'b0, "R9");
        check32("R9", "jump all ones", pc_o, 32'h1FFF_FFFC);
        // R1: reset wins over enable low
        step(mk(2, 'h10), 1'b0, 1'b0, 1'b1, "R1");
        check32("R1", "mid-run reset", pc_o, START);
        // mixed stream
        for (int i = 0; i < 400; i++) begin
            int pick;
            logic [31:0] ins;
            pick = int'($urandom_range(0, 7));
            ins = $urandom;
            case (pick)
                0, 1: ins[31:26] = 6'd4;
                2, 3: ins[31:26] = 6'd5;
                4:    ins[31:26] = 6'd2;
                default: ;
            endcase
            step(ins, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), ($urandom_range(0, 60) == 0),
                 "R3");
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule